// File: doc/BRIEF.md
# Four-Lane 8b/10b Transmit Encoder

This block turns a 32-bit transmit word into four 10-bit line code groups every clock cycle. Each byte lane is encoded with the standard 8b/10b data or control code set. A single running disparity is carried from lane 0 up through lane 3 inside a cycle, and from lane 3 back to lane 0 on the next cycle. Per-lane controls let a lane skip encoding or have its starting disparity overridden. A global enable turns the whole encoder off, and the block then acts as a raw 10-bit-per-lane path.

While encoding is off, the two per-lane disparity control bits become the two top bits of each 10-bit lane. An interface that is a multiple of ten bits wide then gets through to the serializer untouched. The result is registered, so the output follows the input by one clock in both modes.

Top module: `enc8b10b_tx`

## Requirements
- R1: Lane n takes data bits [8n+7:8n] and control bit n of every per-lane input, and drives code_out[10n+9:10n] and k_err[n].
- R2: Outputs are registered and show the result for the inputs of the previous clock. During reset, code_out and k_err are zero and the running disparity is negative.
- R3: With enc_on high, an encoded lane holds the standard 8b/10b group with bit 9 = a, bits 9:4 = abcdei and bits 3:0 = fghj (bit 0 = j). Example: byte 0xB5 (D21.5) gives 10'h2AA.
- R4: With is_k set, the twelve control bytes 0x1C, 0x3C, 0x5C, 0x7C, 0x9C, 0xBC, 0xDC, 0xFC, 0xF7, 0xFB, 0xFD and 0xFE are sent as control groups. Example: 0xBC starting negative gives 10'h0FA, and starting positive gives 10'h305.
- R5: When is_k is set on an encoded lane whose byte is not one of those twelve, k_err for that lane goes high in the same output cycle, and the lane carries the data encoding of the byte.
- R6: The running disparity passes from lane 0 to lane 3 within a cycle. The disparity at the end of lane 3 becomes the starting disparity of lane 0 in the next cycle.
- R7: Every encoded group has four, five or six ones.
- R8: With enc_on high and skip[n] high, lane n outputs {2'b00, byte}, k_err[n] is 0, and the lane leaves the running disparity unchanged.
- R9: On an encoded lane, dmode=0/dval=0 uses the running disparity, dmode=0/dval=1 starts from its inverse, and dmode=1 starts from dval (0 negative, 1 positive). Later lanes continue from the disparity this lane ends with.
- R10: With enc_on low, each lane outputs {dmode, dval, byte}. is_k and skip have no effect, k_err is 0, and the running disparity holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_data | input | 32 | Four transmit bytes, lane 0 in the low byte |
| tx_is_k | input | 4 | Per-lane control-character request |
| tx_skip | input | 4 | Per-lane encoder skip |
| tx_dmode | input | 4 | Per-lane disparity mode, or raw bit 9 when encoding is off |
| tx_dval | input | 4 | Per-lane disparity value, or raw bit 8 when encoding is off |
| enc_on | input | 1 | Global encode enable |
| code_out | output | 40 | Four 10-bit groups, lane 0 in the low ten bits |
| k_err | output | 4 | Per-lane invalid control-byte flag |

## Verification
The weight and disparity assertions assume is_k is asserted with a byte that matches the code tables. A control request on any other byte is reported, not encoded, so R7 still holds when the stimulus sends such a byte on purpose. The skip and raw-mode properties assume the controls are stable for the full cycle before the edge. The bench applies every input at the falling edge to meet this. The random stimulus usually picks control bytes from the valid set and injects invalid ones only now and then. It also keeps the skip and override controls sparse, so long stretches of chained disparity get exercised.

// File: rtl/enc8b10b_pkg.sv
// Shared widths, types and helpers for the four-lane 8b/10b transmit encoder.
package enc8b10b_pkg;

    localparam int BYTE_W  = 8;
    localparam int GROUP_W = 10;

    typedef logic [GROUP_W-1:0] group_t;

    // True when the byte is one of the twelve legal control characters.
    function automatic logic k_byte_ok(input logic [BYTE_W-1:0] b);
        logic [4:0] lo;
        lo = b[4:0];
        return (lo == 5'd28) ||
               ((b[7:5] == 3'd7) &&
                (lo == 5'd23 || lo == 5'd27 || lo == 5'd29 || lo == 5'd30));
    endfunction

endpackage

// File: rtl/enc_blk6.sv
// 5b/6b sub-block encoder.
// Maps the low five bits to abcdei (a in bit 5) and chooses polarity from rd_in.
// Assumes k28 is set only for a valid K.28 control request.
// rd_in/rd_out: 0 = negative, 1 = positive.
module enc_blk6 (
    input  logic [4:0] x,
    input  logic       k28,
    input  logic       rd_in,
    output logic [5:0] c6,
    output logic       rd_out
);

    logic [5:0] base;

    // Negative-disparity form of each 6-bit code.
    always_comb begin
        unique case (x)
            5'd0:  base = 6'b100111;
            5'd1:  base = 6'b011101;
            5'd2:  base = 6'b101101;
            5'd3:  base = 6'b110001;
            5'd4:  base = 6'b110101;
            5'd5:  base = 6'b101001;
            5'd6:  base = 6'b011001;
            5'd7:  base = 6'b111000;
            5'd8:  base = 6'b111001;
            5'd9:  base = 6'b100101;
            5'd10: base = 6'b010101;
            5'd11: base = 6'b110100;
            5'd12: base = 6'b001101;
            5'd13: base = 6'b101100;
            5'd14: base = 6'b011100;
            5'd15: base = 6'b010111;
            5'd16: base = 6'b011011;
            5'd17: base = 6'b100011;
            5'd18: base = 6'b010011;
            5'd19: base = 6'b110010;
            5'd20: base = 6'b001011;
            5'd21: base = 6'b101010;
            5'd22: base = 6'b011010;
            5'd23: base = 6'b111010;
            5'd24: base = 6'b110011;
            5'd25: base = 6'b100110;
            5'd26: base = 6'b010110;
            5'd27: base = 6'b110110;
            5'd28: base = k28 ? 6'b001111 : 6'b001110;
            5'd29: base = 6'b101110;
            5'd30: base = 6'b011110;
            default: base = 6'b101011;
        endcase
    end

    // Polarity: unbalanced codes flip with disparity, x=7 has its own pair.
    always_comb begin
        if ($countones(base) == 3) begin
            c6     = (x == 5'd7 && rd_in) ? 6'b000111 : base;
            rd_out = rd_in;
        end else begin
            c6     = rd_in ? ~base : base;
            rd_out = ~rd_in;
        end
    end

endmodule

// File: rtl/enc_blk4.sv
// 3b/4b sub-block encoder.
// Maps the top three bits to fghj (f in bit 3) using the disparity left by the 6b block.
// Assumes k is set only for a valid control request.
// Picks the alternate .7 form where needed to avoid a run of five.
module enc_blk4 (
    input  logic [2:0] y,
    input  logic [4:0] x,
    input  logic       k,
    input  logic       rd_in,
    output logic [3:0] c4,
    output logic       rd_out
);

    logic       use_alt;
    logic [3:0] base;

    // Alternate .7 selection: always for control, by disparity for six data codes.
    always_comb begin
        use_alt = (y == 3'd7) &&
                  (k ||
                   (!rd_in && (x == 5'd17 || x == 5'd18 || x == 5'd20)) ||
                   ( rd_in && (x == 5'd11 || x == 5'd13 || x == 5'd14)));
    end

    // Negative-disparity form of each 4-bit code.
    always_comb begin
        unique case (y)
            3'd0: base = 4'b1011;
            3'd1: base = 4'b1001;
            3'd2: base = 4'b0101;
            3'd3: base = 4'b1100;
            3'd4: base = 4'b1101;
            3'd5: base = 4'b1010;
            3'd6: base = 4'b0110;
            default: base = use_alt ? 4'b0111 : 4'b1110;
        endcase
    end

    // Polarity rules for unbalanced, .3 and control balanced codes.
    always_comb begin
        rd_out = rd_in;
        if ($countones(base) == 3) begin
            c4     = rd_in ? ~base : base;
            rd_out = ~rd_in;
        end else if (y == 3'd3) begin
            c4 = rd_in ? 4'b0011 : 4'b1100;
        end else if (k) begin
            c4 = rd_in ? base : ~base;
        end else begin
            c4 = base;
        end
    end

endmodule

// File: rtl/enc_lane.sv
// One byte lane of the transmit encoder.
// Applies the disparity override and builds the 10-bit group from both sub-blocks.
// Returns the raw or skip form when encoding is off or skipped.
// Assumes the chained disparity input is settled within the cycle.
module enc_lane
    import enc8b10b_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              is_k,
    input  logic              skip,
    input  logic              dmode,
    input  logic              dval,
    input  logic              enc_on,
    input  logic              rd_in,
    output group_t            grp,
    output logic              err,
    output logic              rd_out
);

    logic       k_ok;
    logic       k_eff;
    logic       rd_start;
    logic [5:0] c6;
    logic [3:0] c4;
    logic       rd6;
    logic       rd4;

    // Control qualification and override of the starting disparity.
    always_comb begin
        k_ok     = k_byte_ok(byte_in);
        k_eff    = is_k && k_ok;
        rd_start = dmode ? dval : (rd_in ^ dval);
    end

    enc_blk6 u_b6 (
        .x      (byte_in[4:0]),
        .k28    (k_eff && byte_in[4:0] == 5'd28),
        .rd_in  (rd_start),
        .c6     (c6),
        .rd_out (rd6)
    );

    enc_blk4 u_b4 (
        .y      (byte_in[7:5]),
        .x      (byte_in[4:0]),
        .k      (k_eff),
        .rd_in  (rd6),
        .c4     (c4),
        .rd_out (rd4)
    );

    // Select raw, skip or encoded output and the outgoing disparity.
    always_comb begin
        if (!enc_on) begin
            grp    = {dmode, dval, byte_in};
            err    = 1'b0;
            rd_out = rd_in;
        end else if (skip) begin
            grp    = {2'b00, byte_in};
            err    = 1'b0;
            rd_out = rd_in;
        end else begin
            grp    = {c6, c4};
            err    = is_k && !k_ok;
            rd_out = rd4;
        end
    end

endmodule

// File: rtl/enc8b10b_tx.sv
// Multi-lane 8b/10b transmit encoder, one clock domain.
// Lanes share a running disparity chained from lane 0 upward, carried between cycles.
// Output groups and error flags are registered (one cycle of latency).
// Assumes synchronous active-low reset; disparity resets to negative.
module enc8b10b_tx
    import enc8b10b_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [LANES*BYTE_W-1:0]    tx_data,
    input  logic [LANES-1:0]           tx_is_k,
    input  logic [LANES-1:0]           tx_skip,
    input  logic [LANES-1:0]           tx_dmode,
    input  logic [LANES-1:0]           tx_dval,
    input  logic                       enc_on,
    output logic [LANES*GROUP_W-1:0]   code_out,
    output logic [LANES-1:0]           k_err
);

    localparam int OUT_W = LANES * GROUP_W;

    logic [LANES:0]   rd_chain;
    logic             rd_q;
    logic [OUT_W-1:0] grp_flat;
    logic [LANES-1:0] err_c;

    assign rd_chain[0] = rd_q;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        group_t grp_i;

        enc_lane u_lane (
            .byte_in (tx_data[i*BYTE_W +: BYTE_W]),
            .is_k    (tx_is_k[i]),
            .skip    (tx_skip[i]),
            .dmode   (tx_dmode[i]),
            .dval    (tx_dval[i]),
            .enc_on  (enc_on),
            .rd_in   (rd_chain[i]),
            .grp     (grp_i),
            .err     (err_c[i]),
            .rd_out  (rd_chain[i+1])
        );

        assign grp_flat[i*GROUP_W +: GROUP_W] = grp_i;
    end

    // Output register and running-disparity state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_out <= '0;
            k_err    <= '0;
            rd_q     <= 1'b0;
        end else begin
            code_out <= grp_flat;
            k_err    <= err_c;
            rd_q     <= rd_chain[LANES];
        end
    end

endmodule

// File: rtl/enc8b10b_tx_chk.sv
// Property checker for the transmit encoder, attached with bind.
// Assumes inputs are stable around the rising clock edge.
module enc8b10b_tx_chk
    import enc8b10b_pkg::*;
#(
    parameter int LANES = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [LANES*BYTE_W-1:0]    tx_data,
    input logic [LANES-1:0]           tx_is_k,
    input logic [LANES-1:0]           tx_skip,
    input logic [LANES-1:0]           tx_dmode,
    input logic [LANES-1:0]           tx_dval,
    input logic                       enc_on,
    input logic [LANES*GROUP_W-1:0]   code_out,
    input logic [LANES-1:0]           k_err,
    input logic                       rd_q
);

    for (genvar i = 0; i < LANES; i++) begin : g_chk
        // R10: raw mode passes {dmode, dval, byte}
        a_r10_raw_lane: assert property (@(posedge clk) disable iff (!rst_n)
            !enc_on |=> code_out[i*GROUP_W +: GROUP_W] ==
                        {$past(tx_dmode[i]), $past(tx_dval[i]), $past(tx_data[i*BYTE_W +: BYTE_W])});

        // R8: skipped lane carries the byte with zero top bits, no error
        a_r8_skip_lane: assert property (@(posedge clk) disable iff (!rst_n)
            (enc_on && tx_skip[i]) |=> (code_out[i*GROUP_W +: GROUP_W] ==
                        {2'b00, $past(tx_data[i*BYTE_W +: BYTE_W])}) && !k_err[i]);

        // R7: encoded groups carry four to six ones
        a_r7_weight_lane: assert property (@(posedge clk) disable iff (!rst_n)
            (enc_on && !tx_skip[i]) |=> ($countones(code_out[i*GROUP_W +: GROUP_W]) >= 4 &&
                                         $countones(code_out[i*GROUP_W +: GROUP_W]) <= 6));

        // R5: error only follows an encoded control request
        a_r5_err_needs_k: assert property (@(posedge clk) disable iff (!rst_n)
            !(enc_on && tx_is_k[i] && !tx_skip[i]) |=> !k_err[i]);
    end

    // R10: disparity holds while encoding is off
    a_r10_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !enc_on |=> rd_q == $past(rd_q));

    // R8: all lanes skipped leaves disparity unchanged
    a_r8_rd_all_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_on && (&tx_skip)) |=> rd_q == $past(rd_q));

endmodule

bind enc8b10b_tx enc8b10b_tx_chk #(.LANES(LANES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_data  (tx_data),
    .tx_is_k  (tx_is_k),
    .tx_skip  (tx_skip),
    .tx_dmode (tx_dmode),
    .tx_dval  (tx_dval),
    .enc_on   (enc_on),
    .code_out (code_out),
    .k_err    (k_err),
    .rd_q     (rd_q)
);

// File: tb/tb_enc8b10b_tx.sv
module tb_enc8b10b_tx;

    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 3000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] tx_data;
    logic [3:0]  tx_is_k, tx_skip, tx_dmode, tx_dval;
    logic        enc_on;
    logic [39:0] code_out;
    logic [3:0]  k_err;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    bit rd_m   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    enc8b10b_tx dut (
        .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_is_k(tx_is_k),
        .tx_skip(tx_skip), .tx_dmode(tx_dmode), .tx_dval(tx_dval),
        .enc_on(enc_on), .code_out(code_out), .k_err(k_err)
    );

    function automatic bit ref_kok(input logic [7:0] b);
        case (b)
            8'h1C, 8'h3C, 8'h5C, 8'h7C, 8'h9C, 8'hBC, 8'hDC, 8'hFC,
            8'hF7, 8'hFB, 8'hFD, 8'hFE: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [5:0] ref_t6(input logic [4:0] x);
        case (x)
            0: return 6'b100111;  1: return 6'b011101;  2: return 6'b101101;  3: return 6'b110001;
            4: return 6'b110101;  5: return 6'b101001;  6: return 6'b011001;  7: return 6'b111000;
            8: return 6'b111001;  9: return 6'b100101; 10: return 6'b010101; 11: return 6'b110100;
           12: return 6'b001101; 13: return 6'b101100; 14: return 6'b011100; 15: return 6'b010111;
           16: return 6'b011011; 17: return 6'b100011; 18: return 6'b010011; 19: return 6'b110010;
           20: return 6'b001011; 21: return 6'b101010; 22: return 6'b011010; 23: return 6'b111010;
           24: return 6'b110011; 25: return 6'b100110; 26: return 6'b010110; 27: return 6'b110110;
           28: return 6'b001110; 29: return 6'b101110; 30: return 6'b011110; default: return 6'b101011;
        endcase
    endfunction

    // Reference 8b/10b group for a byte, control flag and starting disparity.
    function automatic logic [9:0] ref_group(input logic [7:0] b, input bit k, input bit rd);
        logic [4:0] x = b[4:0];
        logic [2:0] y = b[7:5];
        logic [5:0] b6, c6;
        logic [3:0] b4, c4;
        bit r6, alt;
        b6 = (k && x == 5'd28) ? 6'b001111 : ref_t6(x);
        if ($countones(b6) == 3) begin
            c6 = (x == 5'd7 && rd) ? 6'b000111 : b6;
            r6 = rd;
        end else begin
            c6 = rd ? ~b6 : b6;
            r6 = !rd;
        end
        alt = (y == 3'd7) && (k || (r6 ? (x == 11 || x == 13 || x == 14)
                                       : (x == 17 || x == 18 || x == 20)));
        case (y)
            0: b4 = 4'b1011; 1: b4 = 4'b1001; 2: b4 = 4'b0101; 3: b4 = 4'b1100;
            4: b4 = 4'b1101; 5: b4 = 4'b1010; 6: b4 = 4'b0110;
            default: b4 = alt ? 4'b0111 : 4'b1110;
        endcase
        if ($countones(b4) == 3)  c4 = r6 ? ~b4 : b4;
        else if (y == 3'd3)       c4 = r6 ? 4'b0011 : 4'b1100;
        else if (k)               c4 = r6 ? b4 : ~b4;
        else                      c4 = b4;
        return {c6, c4};
    endfunction

    task automatic check(input bit ok, input string req, input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one cycle at a falling edge, predict, and compare one clock later.
    task automatic apply(input logic [31:0] d, input logic [3:0] k, input logic [3:0] sk,
                         input logic [3:0] dm, input logic [3:0] dv, input logic en,
                         input string req);
        logic [39:0] exp_code;
        logic [3:0]  exp_err;
        tx_data = d; tx_is_k = k; tx_skip = sk; tx_dmode = dm; tx_dval = dv; enc_on = en;
        exp_err = '0;
        for (int i = 0; i < 4; i++) begin
            logic [7:0] b = d[i*8 +: 8];
            logic [9:0] g;
            bit st;
            if (!en) begin
                g = {dm[i], dv[i], b};
            end else if (sk[i]) begin
                g = {2'b00, b};
            end else begin
                st = dm[i] ? dv[i] : (rd_m ^ dv[i]);
                exp_err[i] = k[i] && !ref_kok(b);
                g = ref_group(b, k[i] && ref_kok(b), st);
                if ($countones(g) > 5)      rd_m = 1'b1;
                else if ($countones(g) < 5) rd_m = 1'b0;
                else                        rd_m = st;
            end
            exp_code[i*10 +: 10] = g;
        end
        @(negedge clk);
        check(code_out == exp_code, req, code_out, exp_code);
        check(k_err == exp_err, {req, " R5 k_err"}, {36'd0, k_err}, {36'd0, exp_err});
    endtask

    function automatic logic [7:0] pick_k(input int unsigned r);
        case (r % 12)
            0: return 8'h1C; 1: return 8'h3C; 2: return 8'h5C; 3: return 8'h7C;
            4: return 8'h9C; 5: return 8'hBC; 6: return 8'hDC; 7: return 8'hFC;
            8: return 8'hF7; 9: return 8'hFB; 10: return 8'hFD; default: return 8'hFE;
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [3:0]  k, sk, dm, dv;
        logic        en;
        void'($urandom(32'h5EED_0A1B));
        rst_n = 1'b0;
        tx_data = '0; tx_is_k = '0; tx_skip = '0; tx_dmode = '0; tx_dval = '0; enc_on = 1'b0;
        repeat (3) @(negedge clk);
        // R2: reset state
        check(code_out == 40'd0, "R2 reset code_out", code_out, 40'd0);
        check(k_err == 4'd0, "R2 reset k_err", {36'd0, k_err}, 40'd0);
        rst_n = 1'b1;

        // R4 R6: K28.5 on all lanes alternates polarity across lanes
        apply(32'hBCBCBCBC, 4'hF, 4'h0, 4'h0, 4'h0, 1'b1, "R4 R6 K28.5 chain");
        check(code_out[9:0] == 10'h0FA, "R4 lane0 K28.5 neg", {30'd0, code_out[9:0]}, 40'h0FA);
        check(code_out[19:10] == 10'h305, "R6 lane1 K28.5 pos", {30'd0, code_out[19:10]}, 40'h305);
        // R3 R1: D21.5 on all lanes
        apply(32'hB5B5B5B5, 4'h0, 4'h0, 4'h0, 4'h0, 1'b1, "R3 R1 D21.5");
        check(code_out == {4{10'h2AA}}, "R3 D21.5 value", code_out, {4{10'h2AA}});
        // R5: invalid control byte on lane 2
        apply(32'h00000000, 4'h4, 4'h0, 4'h0, 4'h0, 1'b1, "R5 bad K lane2");
        check(k_err == 4'h4, "R5 k_err lane2", {36'd0, k_err}, 40'h4);
        // R9: force positive start on lane 0 with D0.0
        apply(32'h00000000, 4'h0, 4'h0, 4'h1, 4'h1, 1'b1, "R9 force pos");
        check(code_out[9:0] == 10'h18B, "R9 lane0 forced", {30'd0, code_out[9:0]}, 40'h18B);
        // R9: invert and force negative
        apply(32'h03070B0F, 4'h0, 4'h0, 4'h8, 4'h2, 1'b1, "R9 invert and force neg");
        // R10: encoding off, skip and K ignored
        apply(32'h11223344, 4'hF, 4'hF, 4'hA, 4'h6, 1'b0, "R10 raw");
        check(code_out[39:30] == 10'h211, "R10 lane3 raw", {30'd0, code_out[39:30]}, 40'h211);
        // R8: skip lanes 0 and 2
        apply(32'h5A5A5A5A, 4'h5, 4'h5, 4'h0, 4'h0, 1'b1, "R8 skip");
        check(code_out[9:0] == 10'h05A, "R8 lane0 skipped", {30'd0, code_out[9:0]}, 40'h05A);

        for (int n = 0; n < N_RANDOM; n++) begin
            d = $urandom;
            k = '0;
            for (int i = 0; i < 4; i++) begin
                if ($urandom % 4 == 0) begin
                    k[i] = 1'b1;
                    if ($urandom % 8 != 0) d[i*8 +: 8] = pick_k($urandom);
                end
            end
            sk = ($urandom % 8 == 0) ? 4'($urandom) : 4'h0;
            dm = ($urandom % 6 == 0) ? 4'($urandom) : 4'h0;
            dv = ($urandom % 6 == 0) ? 4'($urandom) : 4'h0;
            en = ($urandom % 10 != 0);
            apply(d, k, sk, dm, dv, en, "R1 R3 R4 R6 R7 R8 R9 R10 random");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule